// File: doc/BRIEF.md
# Smart Card Power Sequencer

This block brings a single contact smart card up and down under host control. The host asks for a session by pulling an active-low command line low. The sequencer then switches on the card supply, enables the card I/O, starts the card clock and finally lets the card reset follow the host's reset input. When the host releases the command, or when a fault or a card removal occurs during a session, the block runs the reverse sequence. That sequence ends with the card I/O back in receive mode and the supply off.

After a reset, and again each time the digital supply indication comes back, a power-on lockout must expire before any request is accepted. Requests are taken on the falling edge of the command only. A single active-low status line reports two things. While the command is high, a low level means no card is inserted. While the command is low, a low level means a fault was seen and the card has been shut down, or that a request was refused. The analog supply regulator, comparators, oscillator and pad drivers are outside the block and appear only as digital pins.

Top module: `card_power_seq`

## Requirements
- R1: While reset is held and right after it, supplyEn, ioEn, clkEn and cardRst are all 0, and statusN equals cardPresent while cmdN is high.
- R2: A falling edge of cmdN is ignored until LOCKOUT_CYCLES clock cycles have passed since reset release or since vddGood last returned high. After that window the same edge starts activation.
- R3: Activation starts only on a falling edge of cmdN. A cmdN held low from before the lockout ended does not start it.
- R4: On an accepted edge, supplyEn rises at the clock edge that samples cmdN low. ioEn follows actGap+1 cycles later, then clkEn actGap+1 cycles after that, and the reset release step comes actGap+1 cycles after clkEn. actGap is read at the start of each wait.
- R5: A falling edge with cardPresent low or any fault input high leaves all card outputs off and drives statusN low while cmdN stays low.
- R6: cardRst stays 0 during activation whatever hostRst does. From the reset release step onward it equals hostRst delayed by one clock.
- R7: cmdN going high in a session drives cardRst to 0 at the next clock edge. clkEn falls DEACT_GAP+1 cycles later, ioEn (receive mode) another DEACT_GAP+1 cycles later, and supplyEn another DEACT_GAP+1 cycles later.
- R8: faultOverCurrent, faultOverTemp or faultCardSupply high, cardPresent low, or vddGood low during activation or a session runs the R7 sequence. statusN then goes low from the first edge while cmdN is low.
- R9: With cmdN high, statusN is low exactly when cardPresent is low, and any stored fault indication is cleared.
- R10: After a fault shutdown, outputs stay off while cmdN is held low. A new session needs cmdN to go high and then fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdN | input | 1 | Host session request, active low, edge-triggered |
| hostRst | input | 1 | Host's wish for the card reset level |
| cardPresent | input | 1 | High when a card is inserted |
| faultOverCurrent | input | 1 | Card supply over-current |
| faultOverTemp | input | 1 | Over-temperature |
| faultCardSupply | input | 1 | Card supply below its threshold |
| vddGood | input | 1 | Digital supply above its threshold |
| actGap | input | STEP_W | Wait between activation steps, minus one, in cycles |
| supplyEn | output | 1 | Card supply enable |
| ioEn | output | 1 | Card I/O drive enable; 0 means receive mode |
| clkEn | output | 1 | Card clock enable |
| cardRst | output | 1 | Card reset level |
| statusN | output | 1 | Open-drain style status, low for no card or fault |

## Verification
Every card output is registered. supplyEn appears at the edge that samples the falling command. Each later activation step lands a whole number of actGap+1 cycles after it, and each shutdown step DEACT_GAP+1 cycles after the previous one, counted from the edge that samples the cause. statusN is combinational from cmdN, cardPresent and a flag set on that same edge. The bench drives inputs on the falling clock edge and samples on a falling edge. It checks each output one cycle before its due edge, where it must still be at the old value, and again right after that edge, so an off-by-one in either direction is caught.

// File: rtl/cps_pkg.sv
package cps_pkg;

  typedef enum logic [2:0] {
    S_OFF,
    S_A_IO,
    S_A_CLK,
    S_A_RST,
    S_ON,
    S_D_CLK,
    S_D_IO,
    S_D_PWR
  } seqState_t;

  typedef struct packed {
    logic pwrOn;
    logic ioOn;
    logic clkOn;
    logic rstFollow;
    logic rstLow;
    logic clkOff;
    logic ioOff;
    logic pwrOff;
    logic loadAct;
    logic loadDeact;
    logic setFault;
  } seqStrobe_t;

endpackage

// File: rtl/cps_datapath.sv
module cps_datapath
  import cps_pkg::*;
#(
  parameter int LOCKOUT_CYCLES = 1_000_000,
  parameter int STEP_W         = 8,
  parameter int DEACT_GAP      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              cmdN,
  input  logic              hostRst,
  input  logic              cardPresent,
  input  logic              vddGood,
  input  logic [STEP_W-1:0] actGap,
  output logic              lockDone,
  output logic              gapDone,
  output logic              cmdFall,
  output logic              supplyEn,
  output logic              ioEn,
  output logic              clkEn,
  output logic              cardRst,
  output logic              statusN
);

  localparam int LOCK_W = $clog2(LOCKOUT_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(LOCKOUT_CYCLES);
  localparam logic [STEP_W-1:0] DEACT_LOAD = STEP_W'(DEACT_GAP);

  logic [LOCK_W-1:0] lockCnt;
  logic [STEP_W-1:0] gapCnt;
  logic              cmdPrev;
  logic              faultFlag;

  // power-on lockout, restarted whenever the digital supply drops
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 lockCnt <= '0;
    else if (!vddGood)         lockCnt <= '0;
    else if (lockCnt != LOCK_END) lockCnt <= lockCnt + 1'b1;
  end
  assign lockDone = (lockCnt == LOCK_END) && vddGood;

  // command edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdPrev <= 1'b1;
    else       cmdPrev <= cmdN;
  end
  assign cmdFall = cmdPrev && !cmdN;

  // step spacing counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 gapCnt <= '0;
    else if (strobe.loadAct)   gapCnt <= actGap;
    else if (strobe.loadDeact) gapCnt <= DEACT_LOAD;
    else if (gapCnt != '0)     gapCnt <= gapCnt - 1'b1;
  end
  assign gapDone = (gapCnt == '0);

  // card-facing enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supplyEn <= 1'b0;
      ioEn     <= 1'b0;
      clkEn    <= 1'b0;
      cardRst  <= 1'b0;
    end else begin
      if (strobe.pwrOn)       supplyEn <= 1'b1;
      else if (strobe.pwrOff) supplyEn <= 1'b0;
      if (strobe.ioOn)        ioEn <= 1'b1;
      else if (strobe.ioOff)  ioEn <= 1'b0;
      if (strobe.clkOn)       clkEn <= 1'b1;
      else if (strobe.clkOff) clkEn <= 1'b0;
      if (strobe.rstLow)         cardRst <= 1'b0;
      else if (strobe.rstFollow) cardRst <= hostRst;
    end
  end

  // fault indication, meaningful only while the command is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                faultFlag <= 1'b0;
    else if (cmdN)            faultFlag <= 1'b0;
    else if (strobe.setFault) faultFlag <= 1'b1;
  end
  assign statusN = cmdN ? cardPresent : !faultFlag;

  AST_CLK_NEEDS_IO: assert property (@(posedge clk) disable iff (!rstN) clkEn |-> ioEn); // R4
  AST_IO_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rstN) ioEn |-> supplyEn); // R7
  AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstN) cardRst |-> clkEn); // R6
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN) cmdN |=> (statusN == cardPresent) || !cmdN); // R9

endmodule

// File: rtl/cps_control.sv
module cps_control
  import cps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdN,
  input  logic       cardPresent,
  input  logic       faultOverCurrent,
  input  logic       faultOverTemp,
  input  logic       faultCardSupply,
  input  logic       vddGood,
  input  logic       lockDone,
  input  logic       gapDone,
  input  logic       cmdFall,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;
  logic faultAny, healthy, abortReq, faultCause;

  assign faultAny   = faultOverCurrent || faultOverTemp || faultCardSupply;
  assign healthy    = cardPresent && !faultAny && vddGood;
  assign abortReq   = cmdN || !healthy;
  assign faultCause = !cmdN && !healthy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      S_OFF: begin
        if (cmdFall && lockDone) begin
          if (healthy) begin
            strobe.pwrOn   = 1'b1;
            strobe.loadAct = 1'b1;
            stateNext      = S_A_IO;
          end else begin
            strobe.setFault = 1'b1;
          end
        end
      end
      S_A_IO, S_A_CLK, S_A_RST, S_ON: begin
        if (abortReq) begin
          strobe.rstLow    = 1'b1;
          strobe.loadDeact = 1'b1;
          strobe.setFault  = faultCause;
          stateNext        = S_D_CLK;
        end else if (state == S_ON) begin
          strobe.rstFollow = 1'b1;
        end else if (gapDone) begin
          unique case (state)
            S_A_IO: begin
              strobe.ioOn    = 1'b1;
              strobe.loadAct = 1'b1;
              stateNext      = S_A_CLK;
            end
            S_A_CLK: begin
              strobe.clkOn   = 1'b1;
              strobe.loadAct = 1'b1;
              stateNext      = S_A_RST;
            end
            default: begin
              strobe.rstFollow = 1'b1;
              stateNext        = S_ON;
            end
          endcase
        end
      end
      S_D_CLK: begin
        if (gapDone) begin
          strobe.clkOff    = 1'b1;
          strobe.loadDeact = 1'b1;
          stateNext        = S_D_IO;
        end
      end
      S_D_IO: begin
        if (gapDone) begin
          strobe.ioOff     = 1'b1;
          strobe.loadDeact = 1'b1;
          stateNext        = S_D_PWR;
        end
      end
      default: begin
        if (gapDone) begin
          strobe.pwrOff = 1'b1;
          stateNext     = S_OFF;
        end
      end
    endcase
  end

  AST_LOCKOUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (state == S_OFF && !lockDone) |=> state == S_OFF); // R2
  AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN) (state == S_OFF && !cmdFall) |=> state == S_OFF); // R3
  AST_REJECT_STAYS_OFF: assert property (@(posedge clk) disable iff (!rstN) (state == S_OFF && !cardPresent) |=> state == S_OFF); // R5
  AST_FAULT_SHUTS: assert property (@(posedge clk) disable iff (!rstN) (state == S_ON && faultAny) |=> state == S_D_CLK); // R8
  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rstN) (state == S_ON && cmdN) |=> state == S_D_CLK); // R7

endmodule

// File: rtl/card_power_seq.sv
module card_power_seq
  import cps_pkg::*;
#(
  parameter int LOCKOUT_CYCLES = 1_000_000,
  parameter int STEP_W         = 8,
  parameter int DEACT_GAP      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdN,
  input  logic              hostRst,
  input  logic              cardPresent,
  input  logic              faultOverCurrent,
  input  logic              faultOverTemp,
  input  logic              faultCardSupply,
  input  logic              vddGood,
  input  logic [STEP_W-1:0] actGap,
  output logic              supplyEn,
  output logic              ioEn,
  output logic              clkEn,
  output logic              cardRst,
  output logic              statusN
);

  seqStrobe_t strobe;
  logic lockDone, gapDone, cmdFall;

  cps_control u_control (
    .clk              (clk),
    .rstN             (rstN),
    .cmdN             (cmdN),
    .cardPresent      (cardPresent),
    .faultOverCurrent (faultOverCurrent),
    .faultOverTemp    (faultOverTemp),
    .faultCardSupply  (faultCardSupply),
    .vddGood          (vddGood),
    .lockDone         (lockDone),
    .gapDone          (gapDone),
    .cmdFall          (cmdFall),
    .strobe           (strobe)
  );

  cps_datapath #(
    .LOCKOUT_CYCLES (LOCKOUT_CYCLES),
    .STEP_W         (STEP_W),
    .DEACT_GAP      (DEACT_GAP)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cmdN        (cmdN),
    .hostRst     (hostRst),
    .cardPresent (cardPresent),
    .vddGood     (vddGood),
    .actGap      (actGap),
    .lockDone    (lockDone),
    .gapDone     (gapDone),
    .cmdFall     (cmdFall),
    .supplyEn    (supplyEn),
    .ioEn        (ioEn),
    .clkEn       (clkEn),
    .cardRst     (cardRst),
    .statusN     (statusN)
  );

endmodule

// File: tb/tb_card_power_seq.sv
module tb_card_power_seq;

  localparam int LOCK = 50;
  localparam int SW   = 8;
  localparam int G    = 2;

  logic clk = 1'b0;
  logic rstN, cmdN, hostRst, cardPresent;
  logic faultOverCurrent, faultOverTemp, faultCardSupply, vddGood;
  logic [SW-1:0] actGap;
  logic supplyEn, ioEn, clkEn, cardRst, statusN;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  card_power_seq #(.LOCKOUT_CYCLES(LOCK), .STEP_W(SW), .DEACT_GAP(G)) dut (
    .clk(clk), .rstN(rstN), .cmdN(cmdN), .hostRst(hostRst),
    .cardPresent(cardPresent), .faultOverCurrent(faultOverCurrent),
    .faultOverTemp(faultOverTemp), .faultCardSupply(faultCardSupply),
    .vddGood(vddGood), .actGap(actGap), .supplyEn(supplyEn), .ioEn(ioEn),
    .clkEn(clkEn), .cardRst(cardRst), .statusN(statusN)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; cmdN = 1'b1; hostRst = 1'b0; cardPresent = 1'b1;
    faultOverCurrent = 1'b0; faultOverTemp = 1'b0; faultCardSupply = 1'b0;
    vddGood = 1'b1; actGap = SW'(3);
    tick(3);
    chk("R1", "supplyEn in reset", supplyEn, 1'b0);
    rstN = 1'b1;
    tick(1);
  endtask

  task automatic waitShutdown();
    tick(3 * (G + 1) + 1);
  endtask

  task automatic activateFull(input int gap);
    actGap = SW'(gap);
    cmdN = 1'b0;
    tick(1 + 3 * (gap + 1));
  endtask

  task automatic testReset();
    doReset();
    chk("R1", "supplyEn", supplyEn, 1'b0);
    chk("R1", "ioEn", ioEn, 1'b0);
    chk("R1", "clkEn", clkEn, 1'b0);
    chk("R1", "cardRst", cardRst, 1'b0);
    chk("R1", "statusN card present", statusN, 1'b1);
    cardPresent = 1'b0;
    tick(1);
    chk("R9", "statusN no card", statusN, 1'b0);
    cardPresent = 1'b1;
    tick(1);
    chk("R9", "statusN card back", statusN, 1'b1);
  endtask

  task automatic testLockout();
    doReset();
    tick(5);
    cmdN = 1'b0;
    tick(1);
    chk("R2", "edge in lockout ignored", supplyEn, 1'b0);
    chk("R2", "no fault report in lockout", statusN, 1'b1);
    tick(LOCK);
    chk("R3", "held low level ignored", supplyEn, 1'b0);
    cmdN = 1'b1;
    tick(1);
    cmdN = 1'b0;
    tick(1);
    chk("R2", "edge after lockout accepted", supplyEn, 1'b1);
    cmdN = 1'b1;
    waitShutdown();
    chk("R7", "supply off after abort", supplyEn, 1'b0);
    vddGood = 1'b0;
    tick(2);
    vddGood = 1'b1;
    tick(3);
    cmdN = 1'b0;
    tick(1);
    chk("R2", "edge after supply return ignored", supplyEn, 1'b0);
    cmdN = 1'b1;
    tick(LOCK + 2);
    cmdN = 1'b0;
    tick(1);
    chk("R2", "edge after relock accepted", supplyEn, 1'b1);
    cmdN = 1'b1;
    waitShutdown();
  endtask

  task automatic testActivate(input int gap);
    actGap = SW'(gap);
    hostRst = 1'b1;
    cmdN = 1'b0;
    tick(1);
    chk("R4", "supply at first edge", supplyEn, 1'b1);
    chk("R4", "io not yet", ioEn, 1'b0);
    if (gap > 0) begin tick(gap); chk("R4", "io before due", ioEn, 1'b0); end
    tick(1);
    chk("R4", "io due", ioEn, 1'b1);
    chk("R4", "clk not yet", clkEn, 1'b0);
    if (gap > 0) begin tick(gap); chk("R4", "clk before due", clkEn, 1'b0); end
    tick(1);
    chk("R4", "clk due", clkEn, 1'b1);
    chk("R6", "rst low during activation", cardRst, 1'b0);
    if (gap > 0) begin tick(gap); chk("R6", "rst still low", cardRst, 1'b0); end
    tick(1);
    chk("R6", "rst follows at release step", cardRst, 1'b1);
    hostRst = 1'b0;
    tick(1);
    chk("R6", "rst follows low", cardRst, 1'b0);
    hostRst = 1'b1;
    tick(1);
    chk("R6", "rst follows high", cardRst, 1'b1);
  endtask

  task automatic testHostRelease();
    cmdN = 1'b1;
    tick(1);
    chk("R7", "rst low first", cardRst, 1'b0);
    chk("R7", "clk still on", clkEn, 1'b1);
    tick(G);
    chk("R7", "clk before due", clkEn, 1'b1);
    tick(1);
    chk("R7", "clk off", clkEn, 1'b0);
    chk("R7", "io still on", ioEn, 1'b1);
    tick(G + 1);
    chk("R7", "io receive mode", ioEn, 1'b0);
    chk("R7", "supply still on", supplyEn, 1'b1);
    tick(G + 1);
    chk("R7", "supply off", supplyEn, 1'b0);
    chk("R9", "no fault on host release", statusN, 1'b1);
    hostRst = 1'b0;
  endtask

  task automatic testOverCurrent();
    activateFull(1);
    faultOverCurrent = 1'b1;
    tick(1);
    chk("R8", "status low on fault", statusN, 1'b0);
    chk("R8", "clk on at fault edge", clkEn, 1'b1);
    tick(3 * (G + 1));
    chk("R8", "supply off after fault", supplyEn, 1'b0);
    chk("R8", "io receive after fault", ioEn, 1'b0);
    faultOverCurrent = 1'b0;
    tick(5);
    chk("R10", "no restart while held low", supplyEn, 1'b0);
    chk("R10", "fault still reported", statusN, 1'b0);
    cmdN = 1'b1;
    tick(1);
    chk("R9", "fault cleared by high", statusN, 1'b1);
    cmdN = 1'b0;
    tick(1);
    chk("R10", "restart after re-arm", supplyEn, 1'b1);
    cmdN = 1'b1;
    waitShutdown();
  endtask

  task automatic testRemoval();
    activateFull(0);
    cardPresent = 1'b0;
    tick(1);
    chk("R8", "status low on removal", statusN, 1'b0);
    chk("R8", "rst low on removal", cardRst, 1'b0);
    tick(3 * (G + 1));
    chk("R8", "supply off after removal", supplyEn, 1'b0);
    cmdN = 1'b1;
    tick(1);
    chk("R9", "no card reported", statusN, 1'b0);
    cardPresent = 1'b1;
    tick(1);
    chk("R9", "card back", statusN, 1'b1);
  endtask

  task automatic testFaultDuringActivation();
    actGap = SW'(3);
    cmdN = 1'b0;
    tick(2);
    faultOverTemp = 1'b1;
    tick(1);
    chk("R8", "status low mid activation", statusN, 1'b0);
    chk("R8", "io not enabled", ioEn, 1'b0);
    tick(3 * (G + 1));
    chk("R8", "supply off mid activation", supplyEn, 1'b0);
    faultOverTemp = 1'b0;
    cmdN = 1'b1;
    tick(1);
  endtask

  task automatic testReject();
    faultCardSupply = 1'b1;
    cmdN = 1'b0;
    tick(1);
    chk("R5", "no supply with fault pending", supplyEn, 1'b0);
    chk("R5", "status low on refusal", statusN, 1'b0);
    faultCardSupply = 1'b0;
    tick(5);
    chk("R5", "still off after fault clears", supplyEn, 1'b0);
    cmdN = 1'b1;
    cardPresent = 1'b0;
    tick(1);
    cmdN = 1'b0;
    tick(1);
    chk("R5", "no supply without card", supplyEn, 1'b0);
    cardPresent = 1'b1;
    tick(1);
    chk("R5", "refusal reported", statusN, 1'b0);
    cmdN = 1'b1;
    tick(1);
    chk("R9", "refusal cleared", statusN, 1'b1);
  endtask

  initial begin
    testReset();
    testLockout();
    testActivate(3);
    testHostRelease();
    testActivate(0);
    testHostRelease();
    testOverCurrent();
    testRemoval();
    testFaultDuringActivation();
    testReject();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule